// File: doc/BRIEF.md
# OTP Row Read Controller

A register-mapped read engine for a one-time-programmable fuse array. A processor drives a small 32-bit register file. It checks the fuse-ready status, enables processor access and chooses whether error checking applies to this access. It then writes a 10-bit row number and raises a start bit. The block reads one 41-bit row from a behavioural array model, a fixed number of clock cycles later. It places the row in two data registers and sets a command-done flag. Software clears that flag by writing one to it.

An error-detect status bit reports whether the last completed read hit a fault. The bit can only be set when checking was enabled at launch and the row lies above a configurable threshold. The value stays unchanged until the next completion. Software normally drops the start bit after each read. That falling write, a repeated write of one, a non-read command code, and a start while a read is in flight all leave the engine alone.

Top module: `otp_row_reader`

## Requirements
- R1: After reset, the access control, row, control, status1 and both data registers read 0, and status0 (byte offset 0x18) reads 0x8 while fuse_ready_i is 1.
- R2: Access control (0x00) keeps only bit 15 (processor access enable) and bit 9 (error-check disable), and the row register (0x0C) keeps only the row number in bits 15:6. The control register (0x10) keeps bits 3:0. Unmapped offsets such as 0x04 and 0x28 read 0.
- R3: A write to 0x10 launches a read when wdata bit 0 is 1, the stored start bit is 0, wdata bits 3:1 are 0, access enable is 1, fuse_ready_i is 1 and no read is in flight. Status1 (0x1C) bit 1 then sets exactly LATENCY clock edges after the launching write edge.
- R4: On completion, data-low (0x20) holds {~row[9:0], 12'hC3A, row[9:0]} and data-high (0x24) bits 8:0 hold row[8:0] ^ 9'h1A5, with the upper bits at 0. Both registers change only at completion.
- R5: A start while access enable is 0 or fuse_ready_i is 0 is ignored. No done flag appears, and the data registers keep their values.
- R6: Writing the start bit to 0 after completion, or writing 1 while it is already 1, launches nothing.
- R7: A start written with a non-zero command code in bits 3:1 launches nothing.
- R8: Writing 1 to status1 bit 1 clears the done flag. Writing 0 there leaves it set.
- R9: Status1 bit 17 is set at completion only when error checking was enabled at launch, the row is above ECC_FREE_ROWS (default 15), and the model marks the row faulty (row[2:0] == 3'b101). Otherwise completion clears it, and it holds between completions.
- R10: A start edge while a read is in flight is ignored. The in-flight read completes with the row that was latched at its launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fuse_ready_i | input | 1 | Fuse array ready indication |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable for the selected access |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not selected or unmapped |

## Verification
Rows 0 to 39 are read back-to-back with checking enabled. This sweep crosses the fault pattern on both sides of the threshold, so it separates a wrong threshold comparison from a wrong fault decode. The top rows 1019 to 1023 and row 517 exercise the inverted and XOR-masked data fields with every row bit set. Those rows catch dropped or shifted bits in either data register. Reads with checking disabled, with access disabled, with fuse-ready low, with a non-read code and with a start during a read show that each launch condition is decoded separately.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;
  localparam int ROW_W  = 10;
  localparam int WORD_W = 41;
  localparam int HI_W   = WORD_W - 32;

  localparam logic [7:0] OFS_ACC  = 8'h00;
  localparam logic [7:0] OFS_ROW  = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_ST0  = 8'h18;
  localparam logic [7:0] OFS_ST1  = 8'h1C;
  localparam logic [7:0] OFS_DLO  = 8'h20;
  localparam logic [7:0] OFS_DHI  = 8'h24;

  localparam int ACC_EN_BIT  = 15;
  localparam int ECC_OFF_BIT = 9;
  localparam int ROW_LSB     = 6;
  localparam int READY_BIT   = 3;
  localparam int DONE_BIT    = 1;
  localparam int ECC_BIT     = 17;
endpackage

// File: rtl/otp_fuse_model.sv
module otp_fuse_model
  import otp_rd_pkg::*;
(
  input  logic [ROW_W-1:0]  row_i,
  output logic [WORD_W-1:0] word_o,
  output logic              fault_o
);
  // Deterministic row content stands in for the fuse array
  assign word_o  = {row_i[HI_W-1:0] ^ 9'h1A5, ~row_i, 12'hC3A, row_i};
  assign fault_o = (row_i[2:0] == 3'b101);
endmodule

// File: rtl/otp_rd_seq.sv
module otp_rd_seq
  import otp_rd_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             busy_o,
  output logic             complete_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cnt_q;

  assign complete_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      row_o  <= '0;
    end else if (launch_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(LATENCY - 1);
      row_o  <= row_i;
    end else if (busy_o) begin
      if (complete_o) busy_o <= 1'b0;
      else            cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/otp_row_reader.sv
module otp_row_reader
  import otp_rd_pkg::*;
#(
  parameter int LATENCY       = 4,
  parameter int ECC_FREE_ROWS = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fuse_ready_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o
);
  logic             cpu_en_q, ecc_off_q, ecc_chk_q;
  logic [ROW_W-1:0] row_q;
  logic [3:0]       ctrl_q;
  logic             done_q, ecc_q;
  logic [31:0]      data_lo_q;
  logic [HI_W-1:0]  data_hi_q;

  logic             wr, launch, busy, complete;
  logic [ROW_W-1:0] act_row;
  logic [WORD_W-1:0] word;
  logic             fault;

  assign wr = bus_sel_i && bus_we_i;

  assign launch = wr && (bus_addr_i == OFS_CTRL) && bus_wdata_i[0] && !ctrl_q[0]
                  && (bus_wdata_i[3:1] == 3'b000) && cpu_en_q && fuse_ready_i && !busy;

  otp_rd_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .row_i     (row_q),
    .busy_o    (busy),
    .complete_o(complete),
    .row_o     (act_row)
  );

  otp_fuse_model u_model (
    .row_i  (act_row),
    .word_o (word),
    .fault_o(fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_q  <= 1'b0;
      ecc_off_q <= 1'b0;
      row_q     <= '0;
      ctrl_q    <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        OFS_ACC: begin
          cpu_en_q  <= bus_wdata_i[ACC_EN_BIT];
          ecc_off_q <= bus_wdata_i[ECC_OFF_BIT];
        end
        OFS_ROW:  row_q  <= bus_wdata_i[ROW_LSB +: ROW_W];
        OFS_CTRL: ctrl_q <= bus_wdata_i[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_chk_q <= 1'b0;
      done_q    <= 1'b0;
      ecc_q     <= 1'b0;
      data_lo_q <= '0;
      data_hi_q <= '0;
    end else begin
      if (launch) ecc_chk_q <= !ecc_off_q;
      if (complete) begin
        done_q    <= 1'b1;
        ecc_q     <= ecc_chk_q && (int'(act_row) > ECC_FREE_ROWS) && fault;
        data_lo_q <= word[31:0];
        data_hi_q <= word[WORD_W-1:32];
      end else if (wr && bus_addr_i == OFS_ST1 && bus_wdata_i[DONE_BIT]) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      case (bus_addr_i)
        OFS_ACC: begin
          bus_rdata_o[ACC_EN_BIT]  = cpu_en_q;
          bus_rdata_o[ECC_OFF_BIT] = ecc_off_q;
        end
        OFS_ROW:  bus_rdata_o[ROW_LSB +: ROW_W] = row_q;
        OFS_CTRL: bus_rdata_o[3:0] = ctrl_q;
        OFS_ST0:  bus_rdata_o[READY_BIT] = fuse_ready_i;
        OFS_ST1: begin
          bus_rdata_o[DONE_BIT] = done_q;
          bus_rdata_o[ECC_BIT]  = ecc_q;
        end
        OFS_DLO:  bus_rdata_o = data_lo_q;
        OFS_DHI:  bus_rdata_o[HI_W-1:0] = data_hi_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_rd_checker.sv
module otp_rd_checker
  import otp_rd_pkg::*;
#(
  parameter int LATENCY       = 4,
  parameter int ECC_FREE_ROWS = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fuse_ready_i,
  input logic              cpu_en_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              ecc_i,
  input logic [ROW_W-1:0]  row_i,
  input logic [WORD_W-1:0] data_i
);
  localparam int CW = $clog2(LATENCY + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r5_launch_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cpu_en_i && fuse_ready_i));

  a_r3_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i));

  a_r3_run_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  a_r10_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (int'(run_q) < LATENCY));

  a_r4_data_at_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_i) |-> (done_i && $past(busy_i)));

  a_r9_low_rows_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && ecc_i) |-> (int'(row_i) > ECC_FREE_ROWS));
endmodule

bind otp_row_reader otp_rd_checker #(
  .LATENCY(LATENCY), .ECC_FREE_ROWS(ECC_FREE_ROWS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fuse_ready_i(fuse_ready_i),
  .cpu_en_i    (cpu_en_q),
  .busy_i      (busy),
  .done_i      (done_q),
  .ecc_i       (ecc_q),
  .row_i       (act_row),
  .data_i      ({data_hi_q, data_lo_q})
);

// File: tb/sim_otp_row_reader.sv
`timescale 1ns/1ps
module sim_otp_row_reader;
  localparam int LAT = 4;
  localparam int THR = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fuse_ready = 1'b1;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  otp_row_reader #(.LATENCY(LAT), .ECC_FREE_ROWS(THR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fuse_ready_i(fuse_ready),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 sel = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  function automatic logic [31:0] exp_lo(int r);
    logic [9:0] rr = 10'(r);
    return {~rr, 12'hC3A, rr};
  endfunction

  function automatic logic [31:0] exp_hi(int r);
    logic [9:0] rr = 10'(r);
    return {23'b0, rr[8:0] ^ 9'h1A5};
  endfunction

  // Full read: launch, exact-latency done check, data, ecc, clear
  task automatic do_read(int r, bit ecc_off);
    logic [31:0] v;
    bit exp_ecc;
    wr(8'h00, 32'h8000 | (ecc_off ? 32'h200 : 32'h0));
    wr(8'h0C, 32'(r) << 6);
    @(negedge clk);
    sel = 1; we = 1; addr = 8'h10; wdata = 32'h1;
    @(posedge clk);
    #1 we = 0; addr = 8'h1C;
    repeat (LAT - 1) @(posedge clk);
    #1 check("R3 done early", {31'b0, rdata[1]}, 32'h0);
    @(posedge clk);
    #1 check("R3 done at latency", {31'b0, rdata[1]}, 32'h1);
    sel = 0;
    wr(8'h10, 32'h0);
    rd(8'h20, v); check("R4 data low", v, exp_lo(r));
    rd(8'h24, v); check("R4 data high", v, exp_hi(r));
    exp_ecc = !ecc_off && (r > THR) && ((r % 8) == 5);
    rd(8'h1C, v); check("R9 ecc detect", {31'b0, v[17]}, {31'b0, exp_ecc});
    wr(8'h1C, 32'h2);
    rd(8'h1C, v); check("R8 done cleared", {31'b0, v[1]}, 32'h0);
    check("R9 ecc held after clear", {31'b0, v[17]}, {31'b0, exp_ecc});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    rd(8'h00, v); check("R1 access", v, 0);
    rd(8'h0C, v); check("R1 row", v, 0);
    rd(8'h10, v); check("R1 ctrl", v, 0);
    rd(8'h1C, v); check("R1 status1", v, 0);
    rd(8'h20, v); check("R1 data low", v, 0);
    rd(8'h24, v); check("R1 data high", v, 0);
    rd(8'h18, v); check("R1 status0", v, 32'h8);
    // R2
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 access mask", v, 32'h8200);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R2 row mask", v, 32'hFFC0);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 unmapped 04", v, 0);
    rd(8'h28, v); check("R2 unmapped 28", v, 0);
    wr(8'h00, 32'h0);
    // R5: access disabled
    wr(8'h0C, 32'd21 << 6);
    wr(8'h10, 32'h1); repeat (LAT + 2) @(posedge clk);
    rd(8'h1C, v); check("R5 no done when access off", v, 0);
    wr(8'h10, 32'h0);
    // R5: fuse not ready
    wr(8'h00, 32'h8000);
    fuse_ready = 0;
    rd(8'h18, v); check("R5 status0 not ready", v, 0);
    wr(8'h10, 32'h1); repeat (LAT + 2) @(posedge clk);
    rd(8'h1C, v); check("R5 no done when not ready", v, 0);
    rd(8'h20, v); check("R5 data unchanged", v, 0);
    wr(8'h10, 32'h0);
    fuse_ready = 1;
    // R7: non-read code
    wr(8'h10, 32'h3); repeat (LAT + 2) @(posedge clk);
    rd(8'h1C, v); check("R7 no done for nonzero code", v, 0);
    rd(8'h10, v); check("R2 ctrl readback", v, 32'h3);
    // R6: 1 while already 1 (stored bit 0 is 1)
    wr(8'h10, 32'h1); repeat (LAT + 2) @(posedge clk);
    rd(8'h1C, v); check("R6 no launch without edge", v, 0);
    wr(8'h10, 32'h0);
    // Sweep with checking on
    for (int r = 0; r < 40; r++) do_read(r, 1'b0);
    for (int r = 1019; r < 1024; r++) do_read(r, 1'b0);
    do_read(517, 1'b0);
    // R9 checking disabled
    do_read(21, 1'b1);
    do_read(29, 1'b1);
    do_read(29, 1'b0);
    // R6: falling start after completion launches nothing
    repeat (LAT + 2) @(posedge clk);
    rd(8'h1C, v); check("R6 no relaunch on clear", {31'b0, v[1]}, 0);
    // R8: writing 0 leaves done
    wr(8'h0C, 32'd7 << 6);
    wr(8'h10, 32'h1); repeat (LAT + 1) @(posedge clk);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R8 done kept on write 0", {31'b0, v[1]}, 1);
    wr(8'h1C, 32'h2); wr(8'h10, 32'h0);
    // R10: start during a read
    wr(8'h0C, 32'd100 << 6);
    wr(8'h10, 32'h1);
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'd200 << 6);
    wr(8'h10, 32'h1);
    repeat (LAT + 2) @(posedge clk);
    rd(8'h20, v); check("R10 in-flight row kept", v, exp_lo(100));
    wr(8'h1C, 32'h2);
    repeat (LAT + 2) @(posedge clk);
    rd(8'h1C, v); check("R10 busy start dropped", {31'b0, v[1]}, 0);
    rd(8'h24, v); check("R10 data high kept", v, exp_hi(100));
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule